// File: doc/BRIEF.md
# I2C Display Controller Command Slave

This block is the host-facing side of a 32x4 segment display controller. A fast system clock oversamples the bus clock and data lines. The block recognises START, repeated START and STOP, answers one fixed 7-bit address, and turns the bytes that follow into configuration settings or display-memory traffic. The display memory has 16 bytes, and one byte holds the four common phases of two segment columns.

A write transaction starts with a command byte. Most commands carry one setting byte. The display-data command carries a start address and then any number of data bytes. A read transaction returns memory bytes from the same pointer that writes use. The pointer moves on only after the acknowledge clock of each byte, and it wraps to zero at a limit that depends on how many pins are shared with LED drivers. The display driver reads the memory through a separate scan port. Only an open-drain pull-down enable drives the data line.

Top module: `disp_i2c_cmd_slave`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits are 0111000. Bit 0 of the address byte selects a read when 1 and a write when 0. After any other address, the block stays off the bus until the next START, and the bytes that follow change no state.
- R2: SCL and SDA are synchronized before use. A falling SDA while SCL is high is a START. A rising SDA while SCL is high is a STOP. Either event releases SDA.
- R3: Command 0x82 takes a setting byte. Bit 0 of that byte selects the bias (0 = one third, 1 = one half), and bits 5:4 select the pin-sharing mode.
- R4: Command 0x84 sets the display enable from bit 0 and the oscillator enable from bit 1. Command 0x86 sets the frame-rate code from bits 1:0. Command 0x88 sets the blink code from bits 1:0. Command 0x8A sets the regulator enable from bit 4 and the regulator level from bits 2:0.
- R5: Command 0x80 loads the pointer from bits 3:0 of the next byte. Each data byte after that is stored at the pointer, and the pointer then advances by one.
- R6: The pointer wraps to 0 after address 15 when pin mode bit 1 is 0, after 13 in pin mode 2'b10, and after 11 in pin mode 2'b11.
- R7: After a repeated START with the read bit set, the block returns the byte at the pointer, MSB first. A master ACK advances the pointer (with the R6 wrap) and fetches the next byte. A master NACK ends the read and leaves the pointer unchanged.
- R8: A command byte outside the set listed in R3, R4, R5 and R10 changes no configuration and no pointer, and the rest of that write transaction is ignored.
- R9: Hardware reset selects one-third bias, pin mode 0, oscillator off, display off, regulator off with level 0, frame code 2'b10, blink code 0 and pointer 0.
- R10: The single-byte command 0xAA restores the R9 settings and pointer without touching memory. For INIT_CYCLES clocks after it, every command byte is ignored.
- R11: SDA is pulled low only during an acknowledge clock or while read data bits are being sent.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | Pulls the data line low when 1 |
| scan_addr | input | ADDR_W | Display-driver read address |
| scan_data | output | DATA_W | Memory byte at scan_addr |
| bias_half | output | 1 | 1 = one-half bias, 0 = one-third bias |
| pin_mode | output | 2 | Segment/LED pin-sharing mode |
| osc_en | output | 1 | Oscillator enable |
| disp_en | output | 1 | Display enable |
| vreg_en | output | 1 | Regulator enable |
| vreg_sel | output | 3 | Regulator level code |
| frame_sel | output | 2 | Frame-rate code |
| blink_sel | output | 2 | Blink-rate code |

## Verification
The bench builds the block with the default 16-byte memory and two-stage synchronizers. It sets INIT_CYCLES to 3000, so the quiet window after a soft reset lasts about three bus bytes. One command sent right after the reset therefore falls inside the window, and a later one falls outside it. All three pin modes are exercised, which drives the pointer through each of its wrap limits. A read burst that crosses the top of memory and then ends on a NACK shows both the wrap and the pointer that stays put on NACK.

// File: rtl/disp_i2c_pkg.sv
package disp_i2c_pkg;

  typedef enum logic [3:0] {
    L_IDLE, L_ADDR, L_AACK, L_WR, L_WACK, L_RD, L_RACK, L_RWAIT, L_RLOAD
  } link_state_t;

  typedef enum logic [2:0] {
    P_CMD, P_SET, P_DADDR, P_DATA, P_IGN
  } cmd_phase_t;

  typedef struct packed {
    logic       bias_half;
    logic [1:0] pin_mode;
    logic       osc_en;
    logic       disp_en;
    logic       vreg_en;
    logic [2:0] vreg_sel;
    logic [1:0] frame_sel;
    logic [1:0] blink_sel;
  } disp_cfg_t;

  localparam disp_cfg_t CFG_DEFAULT = '{
    bias_half: 1'b0, pin_mode: 2'b00, osc_en: 1'b0, disp_en: 1'b0,
    vreg_en: 1'b0, vreg_sel: 3'd0, frame_sel: 2'b10, blink_sel: 2'b00
  };

  localparam logic [7:0] OP_DATA  = 8'h80;
  localparam logic [7:0] OP_DRIVE = 8'h82;
  localparam logic [7:0] OP_SYS   = 8'h84;
  localparam logic [7:0] OP_FRAME = 8'h86;
  localparam logic [7:0] OP_BLINK = 8'h88;
  localparam logic [7:0] OP_VREG  = 8'h8A;
  localparam logic [7:0] OP_SRST  = 8'hAA;

endpackage

// File: rtl/disp_i2c_front.sv
module disp_i2c_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic [SYNC_STAGES-1:0] scl_sync_q, sda_sync_q;
  logic                   scl_prev_q, sda_prev_q;
  logic                   scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync_q <= '1;
      sda_sync_q <= '1;
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_sync_q <= {scl_sync_q[SYNC_STAGES-2:0], scl_i};
      sda_sync_q <= {sda_sync_q[SYNC_STAGES-2:0], sda_i};
      scl_prev_q <= scl_s;
      sda_prev_q <= sda_s;
    end
  end

  assign scl_s     = scl_sync_q[SYNC_STAGES-1];
  assign sda_s     = sda_sync_q[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_prev_q;
  assign scl_fall  = ~scl_s & scl_prev_q;
  assign start_evt = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
  assign stop_evt  = scl_s & scl_prev_q & ~sda_prev_q & sda_s;

endmodule

// File: rtl/disp_i2c_link.sv
module disp_i2c_link import disp_i2c_pkg::*; #(
  parameter logic [6:0] SLAVE_ADDR = 7'b0111000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_evt,
  input  logic       stop_evt,
  input  logic [7:0] rd_data,
  output logic       sda_oe,
  output logic       wr_sel,
  output logic       wr_done,
  output logic [7:0] wr_byte,
  output logic       rd_adv
);

  link_state_t state_q, state_d;
  logic [3:0]  bit_q, bit_d;
  logic [7:0]  sh_q, sh_d;
  logic        rw_q, rw_d, mack_q, mack_d, oe_q, oe_d;
  logic        wsel_q, wsel_d, wdone_q, wdone_d, radv_q, radv_d;

  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    rw_d    = rw_q;
    mack_d  = mack_q;
    oe_d    = oe_q;
    wsel_d  = 1'b0;
    wdone_d = 1'b0;
    radv_d  = 1'b0;
    if (stop_evt) begin
      state_d = L_IDLE;
      oe_d    = 1'b0;
    end else if (start_evt) begin
      state_d = L_ADDR;
      bit_d   = 4'd0;
      oe_d    = 1'b0;
    end else begin
      case (state_q)
        L_ADDR, L_WR: begin
          if (scl_rise) begin
            sh_d  = {sh_q[6:0], sda_s};
            bit_d = bit_q + 4'd1;
          end else if (scl_fall && bit_q == 4'd8) begin
            if (state_q == L_WR) begin
              state_d = L_WACK;
              oe_d    = 1'b1;
            end else if (sh_q[7:1] == SLAVE_ADDR) begin
              state_d = L_AACK;
              oe_d    = 1'b1;
              rw_d    = sh_q[0];
            end else begin
              state_d = L_IDLE;
            end
          end
        end
        L_AACK: if (scl_fall) begin
          oe_d  = 1'b0;
          bit_d = 4'd0;
          if (rw_q) state_d = L_RLOAD;
          else begin
            state_d = L_WR;
            wsel_d  = 1'b1;
          end
        end
        L_WACK: if (scl_fall) begin
          oe_d    = 1'b0;
          bit_d   = 4'd0;
          state_d = L_WR;
          wdone_d = 1'b1;
        end
        L_RD: begin
          if (scl_rise) bit_d = bit_q + 4'd1;
          else if (scl_fall) begin
            if (bit_q == 4'd8) begin
              oe_d    = 1'b0;
              state_d = L_RACK;
            end else begin
              sh_d = {sh_q[6:0], 1'b0};
              oe_d = ~sh_q[6];
            end
          end
        end
        L_RACK: begin
          if (scl_rise) mack_d = ~sda_s;
          else if (scl_fall) begin
            if (mack_q) begin
              state_d = L_RWAIT;
              radv_d  = 1'b1;
            end else begin
              state_d = L_IDLE;
            end
          end
        end
        L_RWAIT: state_d = L_RLOAD;
        L_RLOAD: begin
          sh_d    = rd_data;
          oe_d    = ~rd_data[7];
          bit_d   = 4'd0;
          state_d = L_RD;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= L_IDLE;
      bit_q   <= 4'd0;
      sh_q    <= 8'd0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      oe_q    <= 1'b0;
      wsel_q  <= 1'b0;
      wdone_q <= 1'b0;
      radv_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      rw_q    <= rw_d;
      mack_q  <= mack_d;
      oe_q    <= oe_d;
      wsel_q  <= wsel_d;
      wdone_q <= wdone_d;
      radv_q  <= radv_d;
    end
  end

  assign sda_oe  = oe_q;
  assign wr_sel  = wsel_q;
  assign wr_done = wdone_q;
  assign wr_byte = sh_q;
  assign rd_adv  = radv_q;

endmodule

// File: rtl/disp_cmd_regs.sv
module disp_cmd_regs import disp_i2c_pkg::*; #(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int INIT_CYCLES = 32000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_sel,
  input  logic              wr_done,
  input  logic [7:0]        wr_byte,
  input  logic              rd_adv,
  input  logic [ADDR_W-1:0] scan_addr,
  output logic [DATA_W-1:0] scan_data,
  output logic [DATA_W-1:0] rd_data,
  output disp_cfg_t         cfg,
  output logic [ADDR_W-1:0] ptr,
  output logic              busy,
  output logic              cmd_phase,
  output logic              data_phase
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = $clog2(INIT_CYCLES + 1);

  disp_cfg_t         cfg_q, cfg_d;
  cmd_phase_t        ph_q, ph_d;
  logic [7:0]        pend_q, pend_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d, lim, ptr_inc;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              mem_we;
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_comb begin
    if (!cfg_q.pin_mode[1])     lim = ADDR_W'(DEPTH - 1);
    else if (!cfg_q.pin_mode[0]) lim = ADDR_W'(DEPTH - 3);
    else                        lim = ADDR_W'(DEPTH - 5);
    ptr_inc = (ptr_q >= lim) ? '0 : ptr_q + 1'b1;
  end

  always_comb begin
    cfg_d  = cfg_q;
    ph_d   = ph_q;
    pend_d = pend_q;
    ptr_d  = ptr_q;
    cnt_d  = (cnt_q != '0) ? cnt_q - 1'b1 : cnt_q;
    mem_we = 1'b0;
    if (wr_sel) begin
      ph_d = P_CMD;
    end else if (wr_done) begin
      case (ph_q)
        P_CMD: begin
          ph_d = P_IGN;
          if (cnt_q == '0) begin
            case (wr_byte)
              OP_SRST: begin
                cfg_d = CFG_DEFAULT;
                ptr_d = '0;
                cnt_d = CNT_W'(INIT_CYCLES);
              end
              OP_DATA: ph_d = P_DADDR;
              OP_DRIVE, OP_SYS, OP_FRAME, OP_BLINK, OP_VREG: begin
                pend_d = wr_byte;
                ph_d   = P_SET;
              end
              default: ;
            endcase
          end
        end
        P_SET: begin
          ph_d = P_IGN;
          case (pend_q)
            OP_DRIVE: begin
              cfg_d.bias_half = wr_byte[0];
              cfg_d.pin_mode  = wr_byte[5:4];
            end
            OP_SYS: begin
              cfg_d.osc_en  = wr_byte[1];
              cfg_d.disp_en = wr_byte[0];
            end
            OP_FRAME: cfg_d.frame_sel = wr_byte[1:0];
            OP_BLINK: cfg_d.blink_sel = wr_byte[1:0];
            OP_VREG: begin
              cfg_d.vreg_en  = wr_byte[4];
              cfg_d.vreg_sel = wr_byte[2:0];
            end
            default: ;
          endcase
        end
        P_DADDR: begin
          ptr_d = wr_byte[ADDR_W-1:0];
          ph_d  = P_DATA;
        end
        P_DATA: begin
          mem_we = 1'b1;
          ptr_d  = ptr_inc;
        end
        default: ;
      endcase
    end else if (rd_adv) begin
      ptr_d = ptr_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= CFG_DEFAULT;
      ph_q   <= P_IGN;
      pend_q <= 8'd0;
      ptr_q  <= '0;
      cnt_q  <= '0;
    end else begin
      cfg_q  <= cfg_d;
      ph_q   <= ph_d;
      pend_q <= pend_d;
      ptr_q  <= ptr_d;
      cnt_q  <= cnt_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_row
    always_ff @(posedge clk) begin
      if (mem_we && ptr_q == ADDR_W'(g)) mem_q[g] <= wr_byte[DATA_W-1:0];
    end
  end

  assign rd_data    = mem_q[ptr_q];
  assign scan_data  = mem_q[scan_addr];
  assign cfg        = cfg_q;
  assign ptr        = ptr_q;
  assign busy       = (cnt_q != '0);
  assign cmd_phase  = (ph_q == P_CMD);
  assign data_phase = (ph_q == P_DATA);

endmodule

// File: rtl/disp_i2c_cmd_slave.sv
module disp_i2c_cmd_slave import disp_i2c_pkg::*; #(
  parameter int         ADDR_W      = 4,
  parameter int         DATA_W      = 8,
  parameter int         SYNC_STAGES = 2,
  parameter int         INIT_CYCLES = 32000,
  parameter logic [6:0] SLAVE_ADDR  = 7'b0111000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [ADDR_W-1:0] scan_addr,
  output logic [DATA_W-1:0] scan_data,
  output logic              bias_half,
  output logic [1:0]        pin_mode,
  output logic              osc_en,
  output logic              disp_en,
  output logic              vreg_en,
  output logic [2:0]        vreg_sel,
  output logic [1:0]        frame_sel,
  output logic [1:0]        blink_sel
);

  logic              sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic              wr_sel, wr_done, rd_adv, busy, cmd_phase, data_phase;
  logic [7:0]        wr_byte, rd_byte;
  logic [DATA_W-1:0] rd_data;
  logic [ADDR_W-1:0] ptr;
  disp_cfg_t         cfg;

  disp_i2c_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  assign rd_byte = 8'(rd_data);

  disp_i2c_link #(.SLAVE_ADDR(SLAVE_ADDR)) u_link (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
    .rd_data(rd_byte), .sda_oe(sda_oe), .wr_sel(wr_sel),
    .wr_done(wr_done), .wr_byte(wr_byte), .rd_adv(rd_adv)
  );

  disp_cmd_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .INIT_CYCLES(INIT_CYCLES)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel), .wr_done(wr_done),
    .wr_byte(wr_byte), .rd_adv(rd_adv), .scan_addr(scan_addr),
    .scan_data(scan_data), .rd_data(rd_data), .cfg(cfg), .ptr(ptr),
    .busy(busy), .cmd_phase(cmd_phase), .data_phase(data_phase)
  );

  assign bias_half = cfg.bias_half;
  assign pin_mode  = cfg.pin_mode;
  assign osc_en    = cfg.osc_en;
  assign disp_en   = cfg.disp_en;
  assign vreg_en   = cfg.vreg_en;
  assign vreg_sel  = cfg.vreg_sel;
  assign frame_sel = cfg.frame_sel;
  assign blink_sel = cfg.blink_sel;

endmodule

// File: rtl/disp_i2c_cmd_slave_chk.sv
module disp_i2c_cmd_slave_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_evt,
  input logic              stop_evt,
  input logic              sda_oe,
  input logic              rd_adv,
  input logic              wr_done,
  input logic [7:0]        wr_byte,
  input logic              cmd_phase,
  input logic              data_phase,
  input logic              busy,
  input logic [ADDR_W-1:0] ptr,
  input logic [1:0]        pin_mode,
  input logic [12:0]       cfg_bits
);

  localparam int TOP = (1 << ADDR_W) - 1;

  logic [ADDR_W-1:0] top_addr;
  logic              step, known_op;

  assign top_addr = pin_mode == 2'b11 ? ADDR_W'(TOP - 4) :
                    pin_mode == 2'b10 ? ADDR_W'(TOP - 2) : ADDR_W'(TOP);
  assign step     = rd_adv || (wr_done && data_phase);
  assign known_op = wr_byte inside {8'h80, 8'h82, 8'h84, 8'h86, 8'h88, 8'h8A, 8'hAA};

  a_r2_release_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt || stop_evt) |=> !sda_oe);

  a_r6_wrap_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (step && ptr == top_addr) |=> ptr == '0);

  a_r5_pointer_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step && ptr < top_addr) |=> ptr == ADDR_W'($past(ptr) + 1'b1));

  a_r8_unknown_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_done && cmd_phase && !known_op) |=> ($stable(cfg_bits) && $stable(ptr)));

  a_r10_quiet_window: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_done && cmd_phase && busy) |=> ($stable(cfg_bits) && $stable(ptr)));

endmodule

bind disp_i2c_cmd_slave disp_i2c_cmd_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .stop_evt(stop_evt),
  .sda_oe(sda_oe), .rd_adv(rd_adv), .wr_done(wr_done), .wr_byte(wr_byte),
  .cmd_phase(cmd_phase), .data_phase(data_phase), .busy(busy), .ptr(ptr),
  .pin_mode(pin_mode), .cfg_bits(cfg)
);

// File: tb/disp_i2c_cmd_slave_bench.sv
module disp_i2c_cmd_slave_bench;

  localparam int CLK_PERIOD = 10;
  localparam int Q          = 25;
  localparam int INIT_CYC   = 3000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_line;
  logic       sda_oe;
  logic [3:0] scan_addr = 4'd0;
  logic [7:0] scan_data;
  logic       bias_half, osc_en, disp_en, vreg_en;
  logic [1:0] pin_mode, frame_sel, blink_sel;
  logic [2:0] vreg_sel;

  int  n_checks = 0;
  int  n_fail = 0;
  bit  done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] got_byte;
  event       rd_ev;
  logic [7:0] model [16];
  bit         ack;
  logic [7:0] rb;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  disp_i2c_cmd_slave #(.INIT_CYCLES(INIT_CYC)) u_disp_i2c_cmd_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .scan_addr(scan_addr), .scan_data(scan_data), .bias_half(bias_half),
    .pin_mode(pin_mode), .osc_en(osc_en), .disp_en(disp_en), .vreg_en(vreg_en),
    .vreg_sel(vreg_sel), .frame_sel(frame_sel), .blink_sel(blink_sel)
  );

  function automatic logic [12:0] cfg_now();
    return {bias_half, pin_mode, osc_en, disp_en, vreg_en, vreg_sel, frame_sel, blink_sel};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: pops expected read bytes as they arrive
  initial forever begin
    @(rd_ev);
    n_checks++;
    if (exp_q.size() == 0) begin
      n_fail++;
      $display("FAIL R7 unexpected byte actual=0x%0h expected=none", got_byte);
    end else begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      if (got_byte !== e) begin
        n_fail++;
        $display("FAIL %s actual=0x%0h expected=0x%0h", t, got_byte, e);
      end
    end
  end

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
  endtask

  task automatic put_byte(input logic [7:0] b, output bit a);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(Q); scl = 1'b1; wq(2*Q); scl = 1'b0; wq(Q);
    end
    sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q); a = ~sda_line; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic get_byte(input bit master_ack, input logic [7:0] exp, input string tag);
    logic [7:0] b;
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q); scl = 1'b1; wq(Q); b[i] = sda_line; wq(Q); scl = 1'b0; wq(Q);
    end
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    got_byte = b;
    -> rd_ev;
    sda_m = ~master_ack; wq(Q); scl = 1'b1; wq(2*Q); scl = 1'b0; wq(Q); sda_m = 1'b1;
  endtask

  task automatic cmd2(input logic [7:0] c, input logic [7:0] s);
    bit a;
    bus_start(); put_byte(8'h70, a); put_byte(c, a); put_byte(s, a); bus_stop();
  endtask

  task automatic burst(input logic [3:0] at, input logic [7:0] d0, input logic [7:0] d1,
                       input logic [7:0] d2, input int n, input int lim);
    bit a;
    logic [3:0] p;
    logic [7:0] d [3];
    d[0] = d0; d[1] = d1; d[2] = d2;
    p = at;
    bus_start(); put_byte(8'h70, a); put_byte(8'h80, a); put_byte({4'h0, at}, a);
    for (int k = 0; k < n; k++) begin
      put_byte(d[k], a);
      model[p] = d[k];
      p = (int'(p) >= lim) ? 4'd0 : p + 4'd1;
    end
    bus_stop();
  endtask

  task automatic scan_chk(input string req, input logic [3:0] a, input logic [7:0] e);
    scan_addr = a; wq(2);
    check(req, scan_data, e);
  endtask

  initial begin
    logic [12:0] exp_cfg;
    wq(5); rst_n = 1'b1; wq(5);

    // R9 reset state
    check("R9 cfg", cfg_now(), 13'b0_00_0_0_0_000_10_00);
    check("R9 sda released", sda_oe, 0);

    // R1 wrong address: no ACK, no effect
    bus_start(); put_byte(8'h72, ack); check("R1 no ack foreign addr", ack, 0);
    put_byte(8'h84, ack); put_byte(8'h03, ack); bus_stop();
    check("R1 foreign write ignored", disp_en, 0);

    // R1 match + R4 system mode
    bus_start(); put_byte(8'h70, ack); check("R1 ack own addr", ack, 1);
    put_byte(8'h84, ack); put_byte(8'h03, ack); bus_stop();
    check("R4 osc/disp", {osc_en, disp_en}, 2'b11);

    cmd2(8'h86, 8'h01); check("R4 frame", frame_sel, 1);
    cmd2(8'h88, 8'h03); check("R4 blink", blink_sel, 3);
    cmd2(8'h8A, 8'h15); check("R4 regulator", {vreg_en, vreg_sel}, 4'b1101);

    // R3 drive mode
    cmd2(8'h82, 8'h21); check("R3 bias/pins", {bias_half, pin_mode}, 3'b110);

    // R8 unknown command
    exp_cfg = cfg_now();
    cmd2(8'h90, 8'h00); check("R8 unknown op", cfg_now(), exp_cfg);

    // R5/R6 burst wrap with pin mode 2'b10 (limit 13)
    burst(4'd12, 8'hA1, 8'hA2, 8'hA3, 3, 13);
    scan_chk("R5 burst first", 4'd12, 8'hA1);
    scan_chk("R5 burst second", 4'd13, 8'hA2);
    scan_chk("R6 wrap after 13", 4'd0, 8'hA3);

    // R6 pin mode 0 (limit 15)
    cmd2(8'h82, 8'h00);
    burst(4'd15, 8'hB1, 8'hB2, 8'h00, 2, 15);
    scan_chk("R6 at 15", 4'd15, 8'hB1);
    scan_chk("R6 wrap after 15", 4'd0, 8'hB2);

    // R6 pin mode 2'b11 (limit 11)
    cmd2(8'h82, 8'h30);
    burst(4'd10, 8'hC1, 8'hC2, 8'hC3, 3, 11);
    scan_chk("R6 at 11", 4'd11, 8'hC2);
    scan_chk("R6 wrap after 11", 4'd0, 8'hC3);

    // R7 read burst across top of memory, NACK keeps pointer
    cmd2(8'h82, 8'h00);
    burst(4'd14, 8'hE0, 8'hE1, 8'h00, 2, 15);
    bus_start(); put_byte(8'h70, ack); put_byte(8'h80, ack); put_byte(8'h0E, ack);
    bus_start(); put_byte(8'h71, ack); check("R7 read addr ack", ack, 1);
    get_byte(1'b1, model[14], "R7 read byte0");
    get_byte(1'b1, model[15], "R7 read byte1");
    get_byte(1'b0, model[0], "R7 read wrapped");
    bus_stop();
    bus_start(); put_byte(8'h71, ack);
    get_byte(1'b0, model[0], "R7 nack keeps pointer");
    bus_stop();

    // R10 soft reset and quiet window
    bus_start(); put_byte(8'h70, ack); put_byte(8'h80, ack); put_byte(8'h05, ack); bus_stop();
    bus_start(); put_byte(8'h70, ack); put_byte(8'hAA, ack); bus_stop();
    check("R10 defaults", cfg_now(), 13'b0_00_0_0_0_000_10_00);
    cmd2(8'h84, 8'h03); check("R10 window ignores", disp_en, 0);
    wq(INIT_CYC);
    cmd2(8'h84, 8'h03); check("R10 after window", disp_en, 1);
    bus_start(); put_byte(8'h71, ack);
    get_byte(1'b0, model[0], "R10 pointer cleared");
    bus_stop();
    scan_chk("R10 memory kept", 4'd12, 8'hA1);
    check("R11 released at end", sda_oe, 0);

    wq(10);
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule